// File: doc/BRIEF.md
# Centralized Scoreboard Issue Controller

This block schedules instructions over five floating-point execution units: one integer/load unit, two multiplier copies, one adder that handles add and subtract, and one divider. Decoded instructions arrive one at a time in program order. The controller accepts an instruction only when its unit is free and no other unit still owes a result to the same destination register. After that, each instruction advances on its own. It reads its operands once both sources are ready, counts down its fixed execution latency, and then waits for the single write port.

Per unit, the controller holds the destination and source registers, the tags of the producing units and the source-ready flags. Per register, it holds the tag of the pending writer. There is no forwarding and no renaming. A consumer becomes ready only after its producer's result has been written. A finished result is held back while an earlier-issued instruction has not yet read the old value of that register. The arithmetic is out of scope: each unit is modelled as a countdown of its latency.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset no unit is busy, no register has a pending writer, and `rd_grant`, `ex_done` and `wb_valid` are all low.
- R2: Op codes are 0 = load (unit 0, no floating-point sources), 1 = add and 2 = subtract (unit 3), 3 = multiply (unit 1, or unit 2 when unit 1 is busy) and 4 = divide (unit 4). Codes 5 to 7 are never accepted and start nothing.
- R3: Instructions are accepted in order, at most one per cycle. `in_accept` is asserted in the same cycle as `in_valid`, and an instruction whose unit is busy is held.
- R4: An instruction is held while any unit holds a pending write to its destination register.
- R5: `rd_grant` for a unit rises in the first cycle in which both of its sources are ready. A source is ready at issue when it has no pending writer. Otherwise it becomes ready in the cycle after its writer's write, and this includes a write that falls in the issue cycle itself.
- R6: `ex_done` for a unit pulses exactly L cycles after its read grant, with L = 1 for load, 2 for add/subtract, 10 for multiply and 40 for divide.
- R7: A unit may write no earlier than the cycle after its `ex_done`. It waits while another unit that has not yet read its operands lists the destination as a source whose ready flag is still set.
- R8: At most one write occurs per cycle. Among the units eligible to write, the lowest-numbered unit wins and the others wait.
- R9: A write reports the unit and destination register on `wb_unit` and `wb_reg`. From the next cycle, the unit and the register are free for a new issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Operation code (see R2) |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_accept | output | 1 | Instruction issued this cycle |
| in_unit | output | 3 | Unit that receives the issued instruction |
| rd_grant | output | 5 | Per-unit operand-read grant |
| ex_done | output | 5 | Per-unit execution-complete pulse |
| wb_valid | output | 1 | A result is written this cycle |
| wb_unit | output | 3 | Unit that writes |
| wb_reg | output | 5 | Register that is written |

## Verification
The bench builds the block with its default latencies: 1 for load, 2 for add, 10 for multiply and 40 for divide. It sweeps every op code, including the three illegal ones. Because the divide is long, it waits on a multiply while reading a register that a later add overwrites, so a WAR hold of several cycles arises inside a six-instruction program. Because the load and add latencies are short and close together, two instructions that finish in the same cycle are enough to exercise the priority of the write port. Because there are two multiplier copies, one multiply can block a WAW issue while the other writes the stalled instruction's source in the very cycle of that issue.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int REG_AW   = 5;
    localparam int NUM_REGS = 1 << REG_AW;
    localparam int NUM_FU   = 5;
    localparam int FU_IW    = $clog2(NUM_FU + 1);
    localparam int OP_W     = 3;

    localparam int FU_INT   = 0;
    localparam int FU_MUL_A = 1;
    localparam int FU_MUL_B = 2;
    localparam int FU_ADD   = 3;
    localparam int FU_DIV   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_OPERANDS = 2'd1,
        ST_EXECUTE  = 2'd2,
        ST_RESULT   = 2'd3
    } stage_e;

    // one entry of the per-unit status table
    typedef struct packed {
        stage_e            stage;
        logic [REG_AW-1:0] fi;
        logic [REG_AW-1:0] fj;
        logic [REG_AW-1:0] fk;
        logic              fj_v;
        logic              fk_v;
        logic [FU_IW-1:0]  qj;
        logic [FU_IW-1:0]  qk;
        logic              rj;
        logic              rk;
    } fu_stat_t;

    // unit table plus register result table (tag = unit index + 1, 0 = none)
    typedef struct packed {
        fu_stat_t [NUM_FU-1:0]                fu;
        logic     [NUM_REGS-1:0][FU_IW-1:0]   res;
    } sb_state_t;

endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
(
    input  logic              req,
    input  logic [OP_W-1:0]   op,
    input  logic [NUM_FU-1:0] busy,
    input  logic              dst_pending,
    output logic              accept,
    output logic [FU_IW-1:0]  unit
);

    logic legal;

    always_comb begin
        legal = 1'b1;
        unit  = '0;
        case (op)
            OP_LOAD:        unit = FU_IW'(FU_INT);
            OP_ADD, OP_SUB: unit = FU_IW'(FU_ADD);
            OP_MUL:         unit = busy[FU_MUL_A] ? FU_IW'(FU_MUL_B) : FU_IW'(FU_MUL_A);
            OP_DIV:         unit = FU_IW'(FU_DIV);
            default:        legal = 1'b0;
        endcase
        accept = req && legal && !busy[unit] && !dst_pending;
    end

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);

    // the scan runs downward so the lowest requester is the one that remains
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/sb_fu_timer.sv
module sb_fu_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
    import sb_pkg::*;
#(
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 10,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [REG_AW-1:0] in_dst,
    input  logic [REG_AW-1:0] in_src1,
    input  logic [REG_AW-1:0] in_src2,
    output logic              in_accept,
    output logic [FU_IW-1:0]  in_unit,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] ex_done,
    output logic              wb_valid,
    output logic [FU_IW-1:0]  wb_unit,
    output logic [REG_AW-1:0] wb_reg
);

    sb_state_t         st_d, st_q;
    logic [NUM_FU-1:0] busy;
    logic [NUM_FU-1:0] war;
    logic [NUM_FU-1:0] wb_req;
    logic [NUM_FU-1:0] wb_gnt;
    logic [FU_IW-1:0]  wb_tag;
    logic [FU_IW-1:0]  tag_j, tag_k;
    logic              dst_pending;
    logic              uses_src;

    // stage view of the unit table
    always_comb begin
        for (int f = 0; f < NUM_FU; f++) begin
            busy[f]     = (st_q.fu[f].stage != ST_IDLE);
            rd_grant[f] = (st_q.fu[f].stage == ST_OPERANDS) && st_q.fu[f].rj && st_q.fu[f].rk;
        end
    end

    assign dst_pending = (st_q.res[in_dst] != '0);

    sb_issue_ctl u_issue (
        .req         (in_valid),
        .op          (in_op),
        .busy        (busy),
        .dst_pending (dst_pending),
        .accept      (in_accept),
        .unit        (in_unit)
    );

    // a finished unit may not write while an unread earlier reader needs the old value
    always_comb begin
        war = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f && st_q.fu[g].stage == ST_OPERANDS) begin
                    if (st_q.fu[g].fj_v && st_q.fu[g].rj && st_q.fu[g].fj == st_q.fu[f].fi) begin
                        war[f] = 1'b1;
                    end
                    if (st_q.fu[g].fk_v && st_q.fu[g].rk && st_q.fu[g].fk == st_q.fu[f].fi) begin
                        war[f] = 1'b1;
                    end
                end
            end
        end
        for (int f = 0; f < NUM_FU; f++) begin
            wb_req[f] = (st_q.fu[f].stage == ST_RESULT) && !war[f];
        end
    end

    sb_wb_arbiter #(
        .N  (NUM_FU),
        .IW (FU_IW)
    ) u_wb_arb (
        .req (wb_req),
        .gnt (wb_gnt),
        .any (wb_valid),
        .idx (wb_unit)
    );

    assign wb_reg = st_q.fu[wb_unit].fi;
    assign wb_tag = wb_unit + FU_IW'(1);

    // producer tags for the incoming sources, with this cycle's write folded in
    always_comb begin
        uses_src = (in_op != OP_LOAD);
        tag_j    = uses_src ? st_q.res[in_src1] : '0;
        tag_k    = uses_src ? st_q.res[in_src2] : '0;
        if (wb_valid && tag_j == wb_tag) begin
            tag_j = '0;
        end
        if (wb_valid && tag_k == wb_tag) begin
            tag_k = '0;
        end
    end

    // execution countdown per unit, latency picked by unit position
    for (genvar u = 0; u < NUM_FU; u++) begin : g_timer
        localparam int L = (u == FU_INT) ? LAT_INT :
                           (u == FU_ADD) ? LAT_ADD :
                           (u == FU_DIV) ? LAT_DIV : LAT_MUL;
        sb_fu_timer #(
            .LAT (L)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .start (rd_grant[u]),
            .done  (ex_done[u])
        );
    end

    // next state of both tables
    always_comb begin
        st_d = st_q;

        for (int f = 0; f < NUM_FU; f++) begin
            if (rd_grant[f]) begin
                st_d.fu[f].stage = ST_EXECUTE;
                st_d.fu[f].rj    = 1'b0;
                st_d.fu[f].rk    = 1'b0;
            end
            if (ex_done[f]) begin
                st_d.fu[f].stage = ST_RESULT;
            end
            if (wb_valid && st_q.fu[f].qj == wb_tag) begin
                st_d.fu[f].qj = '0;
                st_d.fu[f].rj = 1'b1;
            end
            if (wb_valid && st_q.fu[f].qk == wb_tag) begin
                st_d.fu[f].qk = '0;
                st_d.fu[f].rk = 1'b1;
            end
        end

        if (wb_valid) begin
            st_d.fu[wb_unit].stage        = ST_IDLE;
            st_d.res[st_q.fu[wb_unit].fi] = '0;
        end

        if (in_accept) begin
            st_d.fu[in_unit].stage = ST_OPERANDS;
            st_d.fu[in_unit].fi    = in_dst;
            st_d.fu[in_unit].fj    = in_src1;
            st_d.fu[in_unit].fk    = in_src2;
            st_d.fu[in_unit].fj_v  = uses_src;
            st_d.fu[in_unit].fk_v  = uses_src;
            st_d.fu[in_unit].qj    = tag_j;
            st_d.fu[in_unit].qk    = tag_k;
            st_d.fu[in_unit].rj    = (tag_j == '0);
            st_d.fu[in_unit].rk    = (tag_k == '0);
            st_d.res[in_dst]       = in_unit + FU_IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
#(
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 10,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_accept,
    input logic [FU_IW-1:0]  in_unit,
    input logic [OP_W-1:0]   in_op,
    input logic [REG_AW-1:0] in_dst,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] ex_done,
    input logic              wb_valid,
    input logic [FU_IW-1:0]  wb_unit,
    input logic [REG_AW-1:0] wb_reg,
    input logic [NUM_FU-1:0] wb_gnt
);

    localparam int MAXL_A = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
    localparam int MAXL_B = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int MAXL   = (MAXL_A > MAXL_B) ? MAXL_A : MAXL_B;
    localparam int CW     = $clog2(MAXL + 2);

    logic [NUM_FU-1:0]   occ;
    logic [NUM_REGS-1:0] pend;
    logic [NUM_FU-1:0]   seen;
    logic [CW-1:0]       cnt [NUM_FU];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ  <= '0;
            pend <= '0;
            seen <= '0;
            for (int f = 0; f < NUM_FU; f++) begin
                cnt[f] <= '0;
            end
        end else begin
            if (wb_valid) begin
                occ[wb_unit]  <= 1'b0;
                pend[wb_reg]  <= 1'b0;
                seen[wb_unit] <= 1'b0;
            end
            if (in_accept) begin
                occ[in_unit] <= 1'b1;
                pend[in_dst] <= 1'b1;
            end
            for (int f = 0; f < NUM_FU; f++) begin
                if (ex_done[f]) begin
                    seen[f] <= 1'b1;
                    cnt[f]  <= '0;
                end else if (rd_grant[f]) begin
                    cnt[f] <= CW'(1);
                end else if (cnt[f] != '0) begin
                    cnt[f] <= cnt[f] + 1'b1;
                end
            end
        end
    end

    assert_legal_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_accept |-> (in_op <= 3'd4));

    assert_free_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_accept |-> !occ[in_unit]);

    assert_no_waw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_accept |-> !pend[in_dst]);

    assert_write_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> seen[wb_unit]);

    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_gnt));

    for (genvar f = 0; f < NUM_FU; f++) begin : g_lat
        localparam int L = (f == FU_INT) ? LAT_INT :
                           (f == FU_ADD) ? LAT_ADD :
                           (f == FU_DIV) ? LAT_DIV : LAT_MUL;
        assert_exec_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ex_done[f] |-> (cnt[f] == CW'(L)));
    end

endmodule

bind fu_scoreboard sb_checker #(
    .LAT_INT (LAT_INT),
    .LAT_MUL (LAT_MUL),
    .LAT_ADD (LAT_ADD),
    .LAT_DIV (LAT_DIV)
) u_sb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_accept (in_accept),
    .in_unit   (in_unit),
    .in_op     (in_op),
    .in_dst    (in_dst),
    .rd_grant  (rd_grant),
    .ex_done   (ex_done),
    .wb_valid  (wb_valid),
    .wb_unit   (wb_unit),
    .wb_reg    (wb_reg),
    .wb_gnt    (wb_gnt)
);

// File: tb/fu_scoreboard_bench.sv
module fu_scoreboard_bench;
    import sb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [OP_W-1:0]   in_op = '0;
    logic [REG_AW-1:0] in_dst = '0;
    logic [REG_AW-1:0] in_src1 = '0;
    logic [REG_AW-1:0] in_src2 = '0;
    logic              in_accept;
    logic [FU_IW-1:0]  in_unit;
    logic [NUM_FU-1:0] rd_grant;
    logic [NUM_FU-1:0] ex_done;
    logic              wb_valid;
    logic [FU_IW-1:0]  wb_unit;
    logic [REG_AW-1:0] wb_reg;

    int n_chk = 0;
    int n_fail = 0;

    int p_op [MAXP];
    int p_dst [MAXP];
    int p_s1 [MAXP];
    int p_s2 [MAXP];
    int t_iss [MAXP];
    int t_rd [MAXP];
    int t_ex [MAXP];
    int t_wb [MAXP];
    int t_unit [MAXP];
    int r_wb [MAXP];
    int e_iss [MAXP];
    int e_rd [MAXP];
    int e_ex [MAXP];
    int e_wb [MAXP];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fu_scoreboard u_fu_scoreboard (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_dst    (in_dst),
        .in_src1   (in_src1),
        .in_src2   (in_src2),
        .in_accept (in_accept),
        .in_unit   (in_unit),
        .rd_grant  (rd_grant),
        .ex_done   (ex_done),
        .wb_valid  (wb_valid),
        .wb_unit   (wb_unit),
        .wb_reg    (wb_reg)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put(input int i, input int op, input int dst, input int s1, input int s2);
        p_op[i] = op; p_dst[i] = dst; p_s1[i] = s1; p_s2[i] = s2;
    endtask

    task automatic expect_t(input int i, input int iss, input int rd, input int ex, input int wb);
        e_iss[i] = iss; e_rd[i] = rd; e_ex[i] = ex; e_wb[i] = wb;
    endtask

    // drives a program from cycle 1 and records per-instruction stage cycles
    task automatic run_prog(input int n);
        int idx;
        int cyc;
        int nwb;
        int owner [NUM_FU];
        idx = 0; cyc = 0; nwb = 0;
        for (int i = 0; i < MAXP; i++) begin
            t_iss[i] = -1; t_rd[i] = -1; t_ex[i] = -1; t_wb[i] = -1; t_unit[i] = -1; r_wb[i] = -1;
        end
        for (int u = 0; u < NUM_FU; u++) owner[u] = 0;
        while (nwb < n && cyc < 300) begin
            @(posedge clk); #1;
            cyc++;
            in_valid = (idx < n);
            if (idx < n) begin
                in_op   = OP_W'(p_op[idx]);
                in_dst  = REG_AW'(p_dst[idx]);
                in_src1 = REG_AW'(p_s1[idx]);
                in_src2 = REG_AW'(p_s2[idx]);
            end
            @(negedge clk);
            for (int u = 0; u < NUM_FU; u++) begin
                if (rd_grant[u]) t_rd[owner[u]] = cyc;
                if (ex_done[u]) t_ex[owner[u]] = cyc;
            end
            if (wb_valid) begin
                t_wb[owner[wb_unit]] = cyc;
                r_wb[owner[wb_unit]] = int'(wb_reg);
                nwb++;
            end
            if (in_valid && in_accept) begin
                t_iss[idx]      = cyc;
                t_unit[idx]     = int'(in_unit);
                owner[in_unit]  = idx;
                idx++;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic check_prog(input int n, input string ti, input string tr,
                              input string te, input string tw);
        for (int i = 0; i < n; i++) begin
            chk(ti, $sformatf("instr %0d issue cycle", i), t_iss[i], e_iss[i]);
            chk(tr, $sformatf("instr %0d read cycle", i), t_rd[i], e_rd[i]);
            chk(te, $sformatf("instr %0d exec-done cycle", i), t_ex[i], e_ex[i]);
            chk(tw, $sformatf("instr %0d write cycle", i), t_wb[i], e_wb[i]);
            chk("R9", $sformatf("instr %0d written register", i), r_wb[i], p_dst[i]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual hang, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        int eu;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle outputs after reset
        @(negedge clk);
        chk("R1", "rd_grant after reset", int'(rd_grant), 0);
        chk("R1", "ex_done after reset", int'(ex_done), 0);
        chk("R1", "wb_valid after reset", int'(wb_valid), 0);
        chk("R1", "in_accept without valid", int'(in_accept), 0);

        // R2/R6/R9: every legal op alone, latency computed per op
        for (int op = 0; op < 5; op++) begin
            lat = (op == 0) ? 1 : (op == 3) ? 10 : (op == 4) ? 40 : 2;
            eu  = (op == 0) ? 0 : (op == 3) ? 1 : (op == 4) ? 4 : 3;
            put(0, op, op + 1, 20, 21);
            expect_t(0, 1, 2, 2 + lat, 3 + lat);
            run_prog(1);
            chk("R2", $sformatf("op %0d unit", op), t_unit[0], eu);
            check_prog(1, "R3", "R5", "R6", "R7");
        end

        // R2: illegal codes are never accepted and start nothing
        for (int op = 5; op < 8; op++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_op = OP_W'(op); in_dst = 5'd9;
            @(negedge clk);
            chk("R2", $sformatf("illegal op %0d accept", op), int'(in_accept), 0);
        end
        @(posedge clk); #1 in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "no read after illegal ops", int'(rd_grant), 0);
        chk("R2", "no write after illegal ops", int'(wb_valid), 0);

        // R3/R5/R7: six-instruction reference program (RAW, structural, WAR)
        put(0, 0, 6, 0, 0);
        put(1, 0, 2, 0, 0);
        put(2, 3, 0, 2, 4);
        put(3, 2, 8, 6, 2);
        put(4, 4, 10, 0, 6);
        put(5, 1, 6, 8, 2);
        expect_t(0, 1, 2, 3, 4);
        expect_t(1, 5, 6, 7, 8);
        expect_t(2, 6, 9, 19, 20);
        expect_t(3, 7, 9, 11, 12);
        expect_t(4, 8, 21, 61, 62);
        expect_t(5, 13, 14, 16, 22);
        run_prog(6);
        check_prog(6, "R3", "R5", "R6", "R7");
        chk("R2", "first multiply unit", t_unit[2], 1);

        // R4/R5: WAW hold; source written in the very issue cycle
        put(0, 3, 0, 4, 4);
        put(1, 3, 2, 4, 4);
        put(2, 1, 0, 2, 2);
        expect_t(0, 1, 2, 12, 13);
        expect_t(1, 2, 3, 13, 14);
        expect_t(2, 14, 15, 17, 18);
        run_prog(3);
        check_prog(3, "R4", "R5", "R6", "R9");
        chk("R2", "second multiply goes to unit 2", t_unit[1], 2);

        // R8: load and add finish together, unit 0 writes first
        put(0, 1, 5, 20, 21);
        put(1, 0, 7, 0, 0);
        expect_t(0, 1, 2, 4, 6);
        expect_t(1, 2, 3, 4, 5);
        run_prog(2);
        check_prog(2, "R3", "R5", "R6", "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule